// File: doc/BRIEF.md
# Transactional Footprint Tracker

This block follows the memory footprint of one hardware transaction at cache-line granularity and decides when that transaction has to give up. The core issues commands (begin, end, explicit abort, suspend load tracking, resume load tracking) and reports each load or store it performs as a line identified by a set index and a tag. The coherence side presents remote read and write requests to lines. From these the tracker keeps a read set and a write set inside an 8-way set-associative table with a few sets.

When a remote request collides with the footprint, when a new line finds its set full, or when the core asks for an explicit abort, the tracker pulses abort and publishes a status word for the fallback path. When the core ends the transaction cleanly, it pulses commit. In both cases every tracked line is dropped in a single cycle. A level output tells software whether a transaction is currently running.

Inputs are sampled on the rising clock edge. All outputs are registered, so `tx_active`, `commit_pulse`, `abort_pulse` and `abort_status` reflect a stimulus one cycle after the edge that samples it.

Top module: `tx_footprint_tracker`

## Requirements
- R1: A line is identified by the pair (set index, tag). A remote request that matches the tag in a different set, or the set with a different tag, causes no conflict.
- R2: While a transaction runs, a remote write to a line in the read set or the write set aborts it. The abort status then has bit 1 (conflict) set.
- R3: A remote read to a line in the write set aborts the transaction with bit 1 set. A remote read to a line held only in the read set does not.
- R4: Each set holds up to WAYS (default 8) distinct tracked lines, and repeated accesses to an already tracked line use no new entry. A new line that arrives for a full set aborts the transaction with status bit 2 (capacity) set.
- R5: After a suspend command (opcode 4), loads are not added to the read set, so a remote write to a line loaded only while suspended does not abort. Lines tracked before the suspension still conflict, and stores are still tracked. A resume command (opcode 5) restores load tracking, without adding loads that were made while suspended.
- R6: An explicit-abort command (opcode 3) aborts the transaction in the cycle that samples it. The status then has bit 0 set and the 8-bit code from `cmd_code` in bits 10:3. If several causes occur in the same cycle, their bits are ORed.
- R7: A begin command (opcode 1) sets `tx_active` one cycle later. `tx_active` stays high until the cycle in which the commit pulse or the abort pulse appears.
- R8: An end command (opcode 2) gives a one-cycle commit pulse with no abort pulse. If an abort cause occurs in the same cycle as the end command, only the abort pulse is given.
- R9: Commit and abort clear every tracked line. After the transaction closes, a new transaction sees no conflict on the old lines and has the full capacity again.
- R10: Loads, stores, snoops and every command other than begin are ignored while no transaction runs. A begin command during a transaction is ignored and leaves its footprint intact.
- R11: `abort_status` is zero after reset and is cleared by begin. After an abort it holds its value until the next begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command: 0 none, 1 begin, 2 end, 3 abort, 4 suspend, 5 resume |
| cmd_code | input | CODE_W | Code reported with an explicit abort |
| acc_valid | input | 1 | Core load/store event valid |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_set | input | SET_W | Set index of the accessed line |
| acc_tag | input | TAG_W | Tag of the accessed line |
| snp_valid | input | 1 | Remote request valid |
| snp_write | input | 1 | 1 for a remote write, 0 for a remote read |
| snp_set | input | SET_W | Set index of the remote request |
| snp_tag | input | TAG_W | Tag of the remote request |
| tx_active | output | 1 | Transaction in progress |
| commit_pulse | output | 1 | One-cycle commit indication |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_status | output | CODE_W+3 | Bit 0 explicit, bit 1 conflict, bit 2 capacity, upper bits abort code |

## Verification
The hardest situation to reach is the capacity abort, because it needs WAYS distinct lines in one set inside a single transaction, followed by one more. Reaching it also has to avoid every snoop conflict along the way. The bench does this for every set: it fills the set with alternating loads and stores to distinct tags, then touches an already tracked line and a line in a neighbouring set, both of which must not abort, and only then adds the extra line. The suspended-load case is driven in the same deliberate way. Lines are loaded before suspension, during suspension and after resume, and the bench then snoops each one, so that the cause of any abort can be attributed to a single line.

// File: rtl/tx_footprint_tracker.sv
module tx_footprint_tracker #(
  parameter int SETS   = 4,
  parameter int WAYS   = 8,
  parameter int TAG_W  = 12,
  parameter int CODE_W = 8,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int STAT_W = CODE_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              acc_valid,
  input  logic              acc_store,
  input  logic [SET_W-1:0]  acc_set,
  input  logic [TAG_W-1:0]  acc_tag,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [SET_W-1:0]  snp_set,
  input  logic [TAG_W-1:0]  snp_tag,
  output logic              tx_active,
  output logic              commit_pulse,
  output logic              abort_pulse,
  output logic [STAT_W-1:0] abort_status
);

  localparam logic [2:0] OP_BEGIN   = 3'd1;
  localparam logic [2:0] OP_END     = 3'd2;
  localparam logic [2:0] OP_ABORT   = 3'd3;
  localparam logic [2:0] OP_SUSPEND = 3'd4;
  localparam logic [2:0] OP_RESUME  = 3'd5;

  logic [WAYS-1:0]  ln_valid [SETS];
  logic [WAYS-1:0]  ln_rd    [SETS];
  logic [WAYS-1:0]  ln_wr    [SETS];
  logic [TAG_W-1:0] ln_tag   [SETS][WAYS];
  logic             suspended;

  logic [WAYS-1:0] acc_hit, snp_hit;
  logic [WAY_W-1:0] free_idx;
  logic             has_free;

  for (genvar w = 0; w < WAYS; w++) begin : g_match
    assign acc_hit[w] = ln_valid[acc_set][w] && (ln_tag[acc_set][w] == acc_tag);
    assign snp_hit[w] = ln_valid[snp_set][w] && (ln_tag[snp_set][w] == snp_tag);
  end

  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!ln_valid[acc_set][w]) begin
        free_idx = WAY_W'(w);
        has_free = 1'b1;
      end
    end
  end

  logic track_load, track_store, tracking, need_new;
  logic cap_fail, conflict, explicit_ab, do_abort, do_commit, do_begin;

  assign track_load  = tx_active && acc_valid && !acc_store && !suspended;
  assign track_store = tx_active && acc_valid && acc_store;
  assign tracking    = track_load || track_store;
  assign need_new    = tracking && (acc_hit == '0);
  assign cap_fail    = need_new && !has_free;
  assign conflict    = tx_active && snp_valid &&
                       (snp_write ? (snp_hit != '0) : ((snp_hit & ln_wr[snp_set]) != '0));
  assign explicit_ab = tx_active && (cmd_op == OP_ABORT);
  assign do_abort    = cap_fail || conflict || explicit_ab;
  assign do_commit   = tx_active && (cmd_op == OP_END) && !do_abort;
  assign do_begin    = !tx_active && (cmd_op == OP_BEGIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_active    <= 1'b0;
      commit_pulse <= 1'b0;
      abort_pulse  <= 1'b0;
      abort_status <= '0;
      suspended    <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        ln_valid[s] <= '0;
        ln_rd[s]    <= '0;
        ln_wr[s]    <= '0;
        for (int w = 0; w < WAYS; w++) ln_tag[s][w] <= '0;
      end
    end else begin
      commit_pulse <= do_commit;
      abort_pulse  <= do_abort;
      if (do_begin) begin
        tx_active    <= 1'b1;
        suspended    <= 1'b0;
        abort_status <= '0;
      end else if (do_abort || do_commit) begin
        tx_active <= 1'b0;
        suspended <= 1'b0;
        for (int s = 0; s < SETS; s++) begin
          ln_valid[s] <= '0;
          ln_rd[s]    <= '0;
          ln_wr[s]    <= '0;
        end
        if (do_abort)
          abort_status <= {(explicit_ab ? cmd_code : CODE_W'(0)), cap_fail, conflict, explicit_ab};
      end else if (tx_active) begin
        if (cmd_op == OP_SUSPEND) suspended <= 1'b1;
        if (cmd_op == OP_RESUME)  suspended <= 1'b0;
        if (tracking) begin
          if (!need_new) begin
            if (track_store) ln_wr[acc_set] <= ln_wr[acc_set] | acc_hit;
            else             ln_rd[acc_set] <= ln_rd[acc_set] | acc_hit;
          end else begin
            ln_valid[acc_set][free_idx] <= 1'b1;
            ln_tag[acc_set][free_idx]   <= acc_tag;
            ln_rd[acc_set][free_idx]    <= track_load;
            ln_wr[acc_set][free_idx]    <= track_store;
          end
        end
      end
    end
  end

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_pulse && abort_pulse));

  p_commit_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> !tx_active);

  p_abort_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (!tx_active && abort_status[2:0] != 3'b000));

  p_explicit_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && cmd_op == OP_ABORT) |=>
      (abort_pulse && abort_status[0] && abort_status[STAT_W-1:3] == $past(cmd_code)));

  p_begin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && cmd_op == OP_BEGIN) |=> (tx_active && abort_status == '0));

  p_idle_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && cmd_op != OP_BEGIN) |=> (!tx_active && !commit_pulse && !abort_pulse));

  p_capacity_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_status[2]) |-> $past(tx_active && acc_valid));

endmodule

// File: tb/tx_footprint_tracker_tb_top.sv
module tx_footprint_tracker_tb_top;
  localparam int SETS = 4, WAYS = 8, TAG_W = 12, CODE_W = 8;
  localparam int SET_W = $clog2(SETS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [CODE_W-1:0] cmd_code = '0;
  logic acc_valid = 0, acc_store = 0, snp_valid = 0, snp_write = 0;
  logic [SET_W-1:0] acc_set = '0, snp_set = '0;
  logic [TAG_W-1:0] acc_tag = '0, snp_tag = '0;
  logic tx_active, commit_pulse, abort_pulse;
  logic [CODE_W+2:0] abort_status;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  tx_footprint_tracker #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_code(cmd_code),
    .acc_valid(acc_valid), .acc_store(acc_store), .acc_set(acc_set), .acc_tag(acc_tag),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_set(snp_set), .snp_tag(snp_tag),
    .tx_active(tx_active), .commit_pulse(commit_pulse), .abort_pulse(abort_pulse),
    .abort_status(abort_status));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int op, input int code, input bit av, input bit ast, input int aset,
                     input int atag, input bit sv, input bit sw, input int sset, input int stag);
    cmd_op = 3'(op); cmd_code = CODE_W'(code);
    acc_valid = av; acc_store = ast; acc_set = SET_W'(aset); acc_tag = TAG_W'(atag);
    snp_valid = sv; snp_write = sw; snp_set = SET_W'(sset); snp_tag = TAG_W'(stag);
    @(negedge clk);
    cmd_op = '0; acc_valid = 0; snp_valid = 0;
  endtask

  task automatic cmd(input int op, input int code);
    cyc(op, code, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic acc(input bit st, input int s, input int t);
    cyc(0, 0, 1, st, s, t, 0, 0, 0, 0);
  endtask
  task automatic snp(input bit w, input int s, input int t);
    cyc(0, 0, 0, 0, 0, 0, 1, w, s, t);
  endtask

  task automatic expect_st(input bit a, input bit c, input bit b, input string req);
    chk(tx_active == a && commit_pulse == c && abort_pulse == b, req,
        int'({tx_active, commit_pulse, abort_pulse}), int'({a, c, b}));
  endtask
  task automatic expect_status(input int v, input string req);
    chk(int'(abort_status) == v, req, int'(abort_status), v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_st(0, 0, 0, "R7 reset");
    expect_status(0, "R11 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R10: idle activity ignored
    acc(1, 0, 5); acc(0, 1, 6);
    cmd(2, 0); expect_st(0, 0, 0, "R10 idle end");
    cmd(3, 9); expect_st(0, 0, 0, "R10 idle abort");
    expect_status(0, "R10 idle abort status");
    cmd(4, 0); snp(1, 0, 5); expect_st(0, 0, 0, "R10 idle snoop");
    cmd(1, 0); expect_st(1, 0, 0, "R7 begin");
    snp(1, 0, 5); snp(1, 1, 6); expect_st(1, 0, 0, "R10 idle lines untracked");
    cmd(2, 0); expect_st(0, 1, 0, "R8 commit");
    @(negedge clk); expect_st(0, 0, 0, "R8 pulse width");

    // R1/R2/R3 conflict matrix over all sets
    for (int s = 0; s < SETS; s++)
      for (int ak = 0; ak < 2; ak++)
        for (int sk = 0; sk < 2; sk++) begin
          bit ab;
          ab = (sk == 1) || (ak == 1);
          cmd(1, 0);
          acc(ak[0], s, 7);
          snp(1, (s + 1) % SETS, 7); snp(1, s, 8);
          expect_st(1, 0, 0, "R1 other line");
          snp(sk[0], s, 7);
          if (ab) begin
            expect_st(0, 0, 1, sk == 1 ? "R2 write conflict" : "R3 read vs write set");
            expect_status(2, "R2 conflict bit");
          end else begin
            expect_st(1, 0, 0, "R3 read vs read set");
            cmd(2, 0); expect_st(0, 1, 0, "R8 commit after read snoop");
          end
        end

    // R4 capacity and R9 clearing, every set
    for (int s = 0; s < SETS; s++) begin
      cmd(1, 0);
      for (int w = 0; w < WAYS; w++) begin
        acc(w[0], s, 100 + w);
        expect_st(1, 0, 0, "R4 fill");
      end
      acc(1, s, 100); acc(0, s, 101);
      acc(1, (s + 1) % SETS, 500);
      expect_st(1, 0, 0, "R4 hits and other set");
      acc(0, s, 999);
      expect_st(0, 0, 1, "R4 overflow");
      expect_status(4, "R4 capacity bit");
      cmd(1, 0);
      for (int w = 0; w < WAYS; w++) acc(1, s, 200 + w);
      expect_st(1, 0, 0, "R9 capacity renewed");
      snp(1, s, 103); snp(1, (s + 1) % SETS, 500);
      expect_st(1, 0, 0, "R9 old lines dropped");
      cmd(2, 0); expect_st(0, 1, 0, "R8 commit");
    end
    cmd(1, 0); acc(1, 2, 50); cmd(2, 0);
    cmd(1, 0); snp(1, 2, 50); expect_st(1, 0, 0, "R9 cleared by commit");
    cmd(2, 0);

    // R5 suspend / resume
    cmd(1, 0); acc(0, 0, 1); cmd(4, 0); acc(0, 0, 2); acc(0, 1, 3);
    snp(1, 0, 2); snp(1, 1, 3); expect_st(1, 0, 0, "R5 suspended loads untracked");
    cmd(5, 0); acc(0, 0, 4);
    snp(1, 0, 1); expect_st(0, 0, 1, "R5 earlier line conflicts");
    expect_status(2, "R5 conflict bit");
    cmd(1, 0); cmd(4, 0); acc(0, 0, 2); cmd(5, 0);
    snp(1, 0, 2); expect_st(1, 0, 0, "R5 resume not retroactive");
    acc(0, 0, 2); snp(1, 0, 2); expect_st(0, 0, 1, "R5 resume restores tracking");
    cmd(1, 0); cmd(4, 0); acc(1, 2, 9); snp(0, 2, 9);
    expect_st(0, 0, 1, "R5 stores tracked while suspended");
    cmd(1, 0); cmd(4, 0);
    for (int w = 0; w < WAYS + 2; w++) acc(0, 3, 300 + w);
    expect_st(1, 0, 0, "R5 suspended loads use no capacity");
    cmd(2, 0); expect_st(0, 1, 0, "R8 commit");

    // R6 explicit abort, all codes; R11 hold and clear
    for (int c = 0; c < 256; c++) begin
      cmd(1, 0); expect_status(0, "R11 begin clears");
      cmd(3, c); expect_st(0, 0, 1, "R6 explicit abort");
      expect_status(c * 8 + 1, "R6 status code");
      if (c % 64 == 5) begin
        @(negedge clk); @(negedge clk);
        expect_status(c * 8 + 1, "R11 status held");
      end
    end

    // R10 nested begin ignored
    cmd(1, 0); acc(1, 0, 1); cmd(1, 0);
    expect_st(1, 0, 0, "R10 nested begin");
    snp(1, 0, 1); expect_st(0, 0, 1, "R10 footprint kept");

    // R8 / R6 same-cycle interactions
    cmd(1, 0); acc(1, 1, 5);
    cyc(2, 0, 0, 0, 0, 0, 1, 0, 1, 5);
    expect_st(0, 0, 1, "R8 abort beats end");
    expect_status(2, "R8 abort beats end status");
    cmd(1, 0); acc(0, 2, 6);
    cyc(3, 170, 0, 0, 0, 0, 1, 1, 2, 6);
    expect_status(170 * 8 + 3, "R6 causes ORed");
    cmd(1, 0); cmd(2, 0); expect_status(0, "R11 commit leaves cleared status");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule